// File: doc/BRIEF.md
# Retimer Power and Operating Mode Controller

This block is the control state machine of a video-link retimer. Every reference-clock cycle it chooses one of four states: power-down, standby, redriver or retimer. It bases the choice on output-enable, downstream hot-plug, two register bits for power-down control, the signal-detect enable, a clock-valid flag, a data-rate-above-threshold flag and a two-bit function-mode field. The analog detectors, the clock recovery loop and the PLL are outside the block and appear only as input flags.

From the registered state the block drives the transmitter enable, the clock-recovery enable, the qualified input polarity swap, a status byte and the upstream hot-plug. It also emits a one-cycle configuration-reset pulse when output-enable rises after a long enough low period. Two intervals are counted in reference-clock cycles and set by parameters: the minimum output-enable low time and the acquisition window. A simulation can therefore use short values for both.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The state is power-down when any of these holds: `oe_i` is 0, `pd_force_i` is 1, or `hpd_snk_i` is 0 while `hpd_auto_dis_i` is 0. The power-down state takes priority over every other state.
- R2: `cfg_rst_o` pulses for exactly one cycle after `oe_i` rises, but only if `oe_i` was sampled low on at least `RST_CYC` consecutive clock edges. A shorter low period produces no pulse.
- R3: While `oe_i` is 0, the other control inputs have no effect: `tx_en_o`, `cdr_en_o`, `pol_swap_o` and `hpd_src_o` are all 0.
- R4: Outside power-down, when `sig_det_en_i` is 1 and `clk_valid_i` is 0, the state is standby and both `tx_en_o` and `cdr_en_o` are 0. When `sig_det_en_i` is 0, the clock-valid flag is ignored.
- R5: The effective mode selects the operating state. Mode 00 forces redriver and mode 11 forces retimer. Modes 01 and 10 select retimer when `rate_hi_i` is 1 and redriver otherwise. Redriver means `tx_en_o`=1 and `cdr_en_o`=0. Retimer means both are 1.
- R6: A window of `ACQ_CYC` cycles starts on entry into retimer, and again on a `rate_chg_i` pulse while in retimer. During the window, `tx_en_o` is 0 if `acq_tx_off_i` is 1, and stays 1 if it is 0.
- R7: `pol_swap_o` equals `pol_swap_req_i` in retimer state and is 0 in every other state.
- R8: `hpd_src_o` is `hpd_snk_i` when `hpd_gate_i` is 0 and is held at 0 when `hpd_gate_i` is 1.
- R9: `status_o` bit 7 is 1 in power-down, bit 6 is 1 in standby, and bits 5:0 are always 0.
- R10: A new `func_mode_i` value becomes the effective mode only on a cycle where `oe_i` is 1 and a power-down cause from `pd_force_i` or `hpd_snk_i` is present. At other times the effective mode holds.
- R11: After reset the state is power-down (`status_o`=8'h80), the effective mode is 01, no window is open and `cfg_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Output enable |
| hpd_snk_i | input | 1 | Downstream hot-plug |
| pd_force_i | input | 1 | Forced power-down bit |
| hpd_auto_dis_i | input | 1 | Disables power-down on low hot-plug |
| sig_det_en_i | input | 1 | Signal-detect enable |
| clk_valid_i | input | 1 | Valid input clock detected |
| rate_hi_i | input | 1 | Data rate above crossover threshold |
| rate_chg_i | input | 1 | Rate-change event pulse |
| func_mode_i | input | 2 | Requested function mode |
| acq_tx_off_i | input | 1 | Disable drivers during acquisition |
| hpd_gate_i | input | 1 | Hold upstream hot-plug low |
| pol_swap_req_i | input | 1 | Requested input polarity swap |
| tx_en_o | output | 1 | Transmitter enable (0 = high-Z) |
| cdr_en_o | output | 1 | Clock recovery enable |
| pol_swap_o | output | 1 | Qualified polarity swap |
| hpd_src_o | output | 1 | Upstream hot-plug |
| status_o | output | 8 | Status byte |
| cfg_rst_o | output | 1 | Configuration reset pulse |

## Verification
The state register adds one cycle of latency. A level driven on an input is therefore visible on `tx_en_o`, `cdr_en_o`, `pol_swap_o` and `status_o` after the next rising edge. `hpd_src_o` is combinational. The bench drives every input on a falling edge and samples on the falling edge after the following rising edge.

A mode change takes one cycle to load into the effective mode and a second cycle to reach the state. The acquisition window keeps the drivers off for exactly `ACQ_CYC` samples after the edge that opens it. The reset pulse appears one cycle after the rising edge of `oe_i` and is checked to last exactly one sample.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    ST_PD    = 2'd0,
    ST_STBY  = 2'd1,
    ST_REDRV = 2'd2,
    ST_RETIM = 2'd3
  } pm_state_e;

  localparam logic [1:0] MODE_REDRV = 2'b00;
  localparam logic [1:0] MODE_AUTO  = 2'b01;
  localparam logic [1:0] MODE_RETIM = 2'b11;
endpackage

// File: rtl/pm_oe_qual.sv
module pm_oe_qual #(
  parameter int unsigned RST_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  output logic cfg_rst_o
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt   <= '0;
      cfg_rst_o <= 1'b0;
    end else begin
      cfg_rst_o <= oe_i && (low_cnt == LIM);
      if (oe_i)               low_cnt <= '0;
      else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R2: reset request is a single-cycle pulse
  assert_rst_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_o |=> !cfg_rst_o);
endmodule

// File: rtl/pm_mode_latch.sv
module pm_mode_latch
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] mode_i,
  output logic [1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= MODE_AUTO;
    else if (load_i) mode_o <= mode_i;
  end

  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_o));
endmodule

// File: rtl/pm_acq_timer.sv
module pm_acq_timer #(
  parameter int unsigned ACQ_CYC = 175000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(ACQ_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(ACQ_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (!run_i)       cnt <= '0;
    else if (start_i)      cnt <= LIM;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  assert_acq_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LIM);
  assert_acq_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !busy_o);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned RST_CYC = 2500,
  parameter int unsigned ACQ_CYC = 175000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oe_i,
  input  logic       hpd_snk_i,
  input  logic       pd_force_i,
  input  logic       hpd_auto_dis_i,
  input  logic       sig_det_en_i,
  input  logic       clk_valid_i,
  input  logic       rate_hi_i,
  input  logic       rate_chg_i,
  input  logic [1:0] func_mode_i,
  input  logic       acq_tx_off_i,
  input  logic       hpd_gate_i,
  input  logic       pol_swap_req_i,
  output logic       tx_en_o,
  output logic       cdr_en_o,
  output logic       pol_swap_o,
  output logic       hpd_src_o,
  output logic [7:0] status_o,
  output logic       cfg_rst_o
);
  pm_state_e  state_q, state_d;
  logic [1:0] eff_mode;
  logic       reg_pd_cause, pd_cause, retime_sel, acq_start, acq_busy;

  assign reg_pd_cause = pd_force_i | (~hpd_snk_i & ~hpd_auto_dis_i);
  assign pd_cause     = ~oe_i | reg_pd_cause;
  assign retime_sel   = (eff_mode == MODE_RETIM) |
                        ((eff_mode != MODE_REDRV) & rate_hi_i);

  always_comb begin
    if (pd_cause)                         state_d = ST_PD;
    else if (sig_det_en_i && !clk_valid_i) state_d = ST_STBY;
    else if (retime_sel)                  state_d = ST_RETIM;
    else                                  state_d = ST_REDRV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PD;
    else         state_q <= state_d;
  end

  pm_oe_qual #(.RST_CYC(RST_CYC)) u_oe_qual (
    .clk_i, .rst_ni, .oe_i, .cfg_rst_o
  );

  pm_mode_latch u_mode (
    .clk_i, .rst_ni,
    .load_i (oe_i & reg_pd_cause),
    .mode_i (func_mode_i),
    .mode_o (eff_mode)
  );

  assign acq_start = (state_d == ST_RETIM) && ((state_q != ST_RETIM) || rate_chg_i);

  pm_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk_i, .rst_ni,
    .run_i   (state_d == ST_RETIM),
    .start_i (acq_start),
    .busy_o  (acq_busy)
  );

  assign cdr_en_o   = (state_q == ST_RETIM);
  assign tx_en_o    = (state_q == ST_REDRV) ||
                      ((state_q == ST_RETIM) && !(acq_busy && acq_tx_off_i));
  assign pol_swap_o = pol_swap_req_i && (state_q == ST_RETIM);
  assign hpd_src_o  = oe_i & hpd_snk_i & ~hpd_gate_i;
  assign status_o   = {state_q == ST_PD, state_q == ST_STBY, 6'b0};

  assert_oe_low_pd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (status_o[7] && !tx_en_o && !cdr_en_o));
  assert_oe_hpd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !hpd_src_o);
  assert_pol_retimer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_swap_o |-> cdr_en_o);
  assert_status_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[7:6]) && (status_o[5:0] == 6'b0));
  assert_stby_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> (!tx_en_o && !cdr_en_o));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int RST_CYC = 5;
  localparam int ACQ_CYC = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic oe, hpd, pdf, ad, sde, cv, rh, rc, aoff, gate, preq;
  logic [1:0] fm;
  logic tx_en, cdr_en, pol, hpd_src, cfg_rst;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.RST_CYC(RST_CYC), .ACQ_CYC(ACQ_CYC)) dut (
    .clk_i(clk), .rst_ni, .oe_i(oe), .hpd_snk_i(hpd), .pd_force_i(pdf),
    .hpd_auto_dis_i(ad), .sig_det_en_i(sde), .clk_valid_i(cv), .rate_hi_i(rh),
    .rate_chg_i(rc), .func_mode_i(fm), .acq_tx_off_i(aoff), .hpd_gate_i(gate),
    .pol_swap_req_i(preq), .tx_en_o(tx_en), .cdr_en_o(cdr_en), .pol_swap_o(pol),
    .hpd_src_o(hpd_src), .status_o(status), .cfg_rst_o(cfg_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic run_normal();
    oe = 1; hpd = 1; pdf = 0; ad = 0; sde = 0; cv = 1; rc = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    fm = m; pdf = 1; step(2); pdf = 0; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    run_normal(); rh = 0; fm = 2'b01; aoff = 0; gate = 0; preq = 1;
    step(2);
    // R11 reset state
    chk("R11 status", status, 8'h80);
    chk("R11 tx/cdr/rst", {5'b0, tx_en, cdr_en, cfg_rst}, 8'h00);
    rst_ni = 1;
    step(1);
    // R5: default mode auto, rate low -> redriver
    chk("R11 R5 default auto mode", {6'b0, tx_en, cdr_en}, 8'h02);

    // exhaustive sweep: 4 modes x 128 input combos
    for (int m = 0; m < 4; m++) begin
      run_normal(); set_mode(m[1:0]);
      for (int i = 0; i < 128; i++) begin
        logic e_pd, e_sb, e_rt;
        oe = i[0]; pdf = i[1]; hpd = i[2]; ad = i[3]; sde = i[4]; cv = i[5]; rh = i[6];
        gate = i[0] ^ i[3]; preq = i[1] | i[5];
        step(1);
        e_pd = !oe | pdf | (!hpd & !ad);
        e_sb = !e_pd & sde & !cv;
        e_rt = !e_pd & !e_sb & ((m == 3) | ((m != 0) & rh));
        chk("R1 R4 R9 status", status, {e_pd, e_sb, 6'b0});
        chk("R3 R4 R5 tx/cdr", {6'b0, tx_en, cdr_en},
            {6'b0, !e_pd & !e_sb, e_rt});
        chk("R7 polarity", {7'b0, pol}, {7'b0, preq & e_rt});
        chk("R3 R8 hpd_src", {7'b0, hpd_src}, {7'b0, oe & hpd & !gate});
      end
    end

    // R10: mode change waits for a power-down toggle
    run_normal(); rh = 1; preq = 0; gate = 0; aoff = 0;
    set_mode(2'b00);
    chk("R10 R5 mode 00 redriver", {6'b0, tx_en, cdr_en}, 8'h02);
    fm = 2'b11; step(4);
    chk("R10 no toggle, no change", {6'b0, tx_en, cdr_en}, 8'h02);
    hpd = 0; step(2); hpd = 1; step(1);
    chk("R10 after hpd toggle retimer", {6'b0, tx_en, cdr_en}, 8'h03);
    fm = 2'b10; pdf = 1; step(1); pdf = 0; rh = 0; step(1);
    chk("R5 mode 10 rate low redriver", {6'b0, tx_en, cdr_en}, 8'h02);
    rh = 1; step(1);
    chk("R5 mode 10 rate high retimer", {6'b0, tx_en, cdr_en}, 8'h03);

    // R6: acquisition window with drivers held off
    aoff = 1; rh = 0; step(1);
    rh = 1;
    for (int k = 1; k <= ACQ_CYC + 1; k++) begin
      step(1);
      chk("R6 entry window tx", {7'b0, tx_en}, {7'b0, k > ACQ_CYC});
    end
    chk("R6 cdr on in window", {7'b0, cdr_en}, 8'h01);
    rc = 1; step(1); rc = 0;
    chk("R6 rate change reopens", {7'b0, tx_en}, 8'h00);
    for (int k = 2; k <= ACQ_CYC + 1; k++) begin
      step(1);
      chk("R6 rate change window tx", {7'b0, tx_en}, {7'b0, k > ACQ_CYC});
    end
    aoff = 0; rc = 1; step(1); rc = 0;
    chk("R6 drivers stay on when bit clear", {7'b0, tx_en}, 8'h01);

    // R2: OE-low qualification
    oe = 0; step(RST_CYC - 1);
    chk("R3 hpd_src low while oe low", {7'b0, hpd_src}, 8'h00);
    oe = 1; step(1);
    chk("R2 short low no pulse", {7'b0, cfg_rst}, 8'h00);
    step(1);
    chk("R2 short low no pulse later", {7'b0, cfg_rst}, 8'h00);
    oe = 0; step(RST_CYC);
    oe = 1; step(1);
    chk("R2 qualified pulse", {7'b0, cfg_rst}, 8'h01);
    step(1);
    chk("R2 pulse one cycle", {7'b0, cfg_rst}, 8'h00);
    oe = 0; step(RST_CYC + 20);
    oe = 1; step(1);
    chk("R2 long low pulse", {7'b0, cfg_rst}, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule